// File: doc/BRIEF.md
# Transition-Compressed Timing Capture Engine

This block is the acquisition front end of a multi-channel logic analyzer working in timing mode. It watches a bundle of probe lines that are asynchronous to its own clock. It stays idle and emits nothing until a pattern trigger matches. After the trigger, it samples every probe line on a local timebase whose rate is set by a divider. It does not store every sample. Each channel keeps its own count of sample ticks since that channel last changed. When the channel changes level, the engine emits one record holding the channel number, the new level and that count. A slow timebase can therefore cover a long window when edges are rare.

A glitch-hunting mode keeps only the edges that follow the previous edge on the same channel by fewer ticks than a programmable threshold. Outside that mode, a channel that stays quiet long enough for its count to saturate emits a flagged keep-alive record. This lets a consumer that rebuilds the waveform keep an exact time axis. Records leave through a valid/ready stream. While the consumer stalls, sampling pauses but the tick count keeps running, so a level change that persists is still reported, with the correct elapsed time.

Top module: `tcap_engine`

## Requirements
- R1: After reset `rec_valid` is 0. No record is produced before the trigger has fired, whatever the probe lines do.
- R2: Bit i of `probe_in` is channel i. Each channel passes through a two-stage synchroniser. On each sample tick before the trigger, the engine fires when `((sync ^ trig_value) & trig_mask) == 0`. A mask of all zeros fires on the first tick. Changes on masked-out channels do not fire the trigger. The synchronised levels at the firing tick become every channel's reference level.
- R3: After the trigger, a change of a channel's synchronised level at a tick produces one record. That record has `rec_chan` = the binary channel number, `rec_level` = the new level, `rec_keep` = 0, and `rec_delta` = the number of ticks since that channel's previous change, or since the trigger tick.
- R4: A sample tick occurs once every `rate_div`+1 clock cycles, so 0 means every cycle. Deltas count ticks, not clock cycles.
- R5: Outside glitch mode, when a channel's count reaches 2^DW-1 ticks without a change, the engine emits a record with `rec_keep` = 1, `rec_delta` all ones and the channel's current level, and restarts that count. In glitch mode no keep-alive record is ever produced.
- R6: With `glitch_en` = 1, a change is reported only when its delta is strictly less than `glitch_thr`. Other changes still update the channel's level and restart its count, but emit nothing.
- R7: Records for channels that change on the same tick leave in ascending channel order.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, the record on the outputs stays unchanged. Sampling pauses while any record waits to be sent. A change that occurs during the pause is reported at the first tick after it, with a delta that includes the paused ticks. No persisting change is lost.
- R9: `rec_delta` of any record is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset; re-arms the trigger |
| probe_in | input | NCH | Asynchronous probe lines, bit i = channel i |
| trig_mask | input | NCH | Channels taking part in the trigger pattern |
| trig_value | input | NCH | Required levels of the masked channels |
| rate_div | input | DIVW | Tick every rate_div+1 cycles |
| glitch_en | input | 1 | Report only short-interval changes |
| glitch_thr | input | DW | Exclusive delta limit in glitch mode |
| rec_valid | output | 1 | A record is on the outputs |
| rec_ready | input | 1 | Consumer accepts the record this cycle |
| rec_chan | output | $clog2(NCH) | Channel number of the record |
| rec_level | output | 1 | Channel level after the change |
| rec_delta | output | DW | Ticks since the channel's previous change |
| rec_keep | output | 1 | Keep-alive record flag |

## Verification
On every cycle, the assertions watch the output stream for the invariants. The stream is silent before the trigger. A stalled record holds still. A keep-alive record carries a saturated delta. In glitch mode every record lies under the threshold. No delta is zero. The actual delta values, the order of records within a tick, the alignment of the trigger reference, the pause of sampling under back-pressure and the divider rate appear only in the bench's scenarios. These scenarios compare the full record stream against the arithmetic expectation, including a sweep over divider settings and edge spacings.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

   typedef enum logic {
      ACQ_ARMED = 1'b0,
      ACQ_RUN   = 1'b1
   } acq_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcap_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else if (s == 0) begin
               stage_q[s] <= d_async;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/tcap_ratediv.sv
module tcap_ratediv #(
   parameter int unsigned DIVW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] rate_div,
   output logic            tick
);
   logic [DIVW-1:0] phase_q;

   assign tick = (phase_q >= rate_div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/tcap_lane.sv
module tcap_lane #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          running,
   input  logic          start,
   input  logic          tick,
   input  logic          sample_en,
   input  logic          level_in,
   input  logic          glitch_en,
   input  logic [DW-1:0] glitch_thr,
   input  logic          grant,
   output logic          pend,
   output logic          out_level,
   output logic [DW-1:0] out_delta,
   output logic          out_keep
);
   localparam logic [DW-1:0] SAT = '1;

   logic          last_q;
   logic [DW-1:0] count_q;
   logic [DW-1:0] next_cnt;
   logic          edge_seen;
   logic          saturated;
   logic          keep_ok;

   assign next_cnt  = (count_q == SAT) ? SAT : count_q + 1'b1;
   assign edge_seen = sample_en && (level_in != last_q);
   assign saturated = (next_cnt == SAT);
   assign keep_ok   = !glitch_en || (next_cnt < glitch_thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q    <= 1'b0;
         count_q   <= '0;
         pend      <= 1'b0;
         out_level <= 1'b0;
         out_delta <= '0;
         out_keep  <= 1'b0;
      end else begin
         if (grant) begin
            pend <= 1'b0;
         end
         if (start) begin
            last_q  <= level_in;
            count_q <= '0;
         end else if (running && tick) begin
            if (edge_seen) begin
               last_q  <= level_in;
               count_q <= '0;
               if (keep_ok) begin
                  pend      <= 1'b1;
                  out_level <= level_in;
                  out_delta <= next_cnt;
                  out_keep  <= 1'b0;
               end
            end else if (sample_en && saturated && !glitch_en) begin
               count_q   <= '0;
               pend      <= 1'b1;
               out_level <= last_q;
               out_delta <= next_cnt;
               out_keep  <= 1'b1;
            end else begin
               count_q <= next_cnt;
            end
         end
      end
   end
endmodule

// File: rtl/tcap_fmt.sv
module tcap_fmt #(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 16,
   parameter int unsigned CW  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          pend,
   input  logic [NCH-1:0]          lane_level,
   input  logic [NCH-1:0][DW-1:0]  lane_delta,
   input  logic [NCH-1:0]          lane_keep,
   output logic [NCH-1:0]          grant,
   output logic                    rec_valid,
   input  logic                    rec_ready,
   output logic [CW-1:0]           rec_chan,
   output logic                    rec_level,
   output logic [DW-1:0]           rec_delta,
   output logic                    rec_keep
);
   logic [CW-1:0] pick;
   logic          any;
   logic          load;

   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int i = NCH-1; i >= 0; i--) begin
         if (pend[i]) begin
            pick = CW'(i);
            any  = 1'b1;
         end
      end
   end

   assign load = any && (!rec_valid || rec_ready);

   always_comb begin
      grant = '0;
      if (load) begin
         grant[pick] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_valid <= 1'b0;
         rec_chan  <= '0;
         rec_level <= 1'b0;
         rec_delta <= '0;
         rec_keep  <= 1'b0;
      end else if (!rec_valid || rec_ready) begin
         rec_valid <= any;
         if (any) begin
            rec_chan  <= pick;
            rec_level <= lane_level[pick];
            rec_delta <= lane_delta[pick];
            rec_keep  <= lane_keep[pick];
         end
      end
   end
endmodule

// File: rtl/tcap_engine.sv
module tcap_engine #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned DW   = 16,
   parameter int unsigned DIVW = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [NCH-1:0]                         probe_in,
   input  logic [NCH-1:0]                         trig_mask,
   input  logic [NCH-1:0]                         trig_value,
   input  logic [DIVW-1:0]                        rate_div,
   input  logic                                   glitch_en,
   input  logic [DW-1:0]                          glitch_thr,
   output logic                                   rec_valid,
   input  logic                                   rec_ready,
   output logic [tcap_pkg::idx_width(NCH)-1:0]    rec_chan,
   output logic                                   rec_level,
   output logic [DW-1:0]                          rec_delta,
   output logic                                   rec_keep
);
   import tcap_pkg::*;

   localparam int unsigned CW = idx_width(NCH);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("tcap_engine needs at least two channels");
      end
      if (DW < 2) begin : g_bad_dw
         $error("tcap_engine delta width must be at least two bits");
      end
      if (DIVW < 1) begin : g_bad_divw
         $error("tcap_engine divider width must be at least one bit");
      end
   endgenerate

   logic [NCH-1:0]         smp;
   logic                   tick;
   logic [NCH-1:0]         pend;
   logic [NCH-1:0]         grant;
   logic [NCH-1:0]         lane_level;
   logic [NCH-1:0][DW-1:0] lane_delta;
   logic [NCH-1:0]         lane_keep;
   acq_state_t             state_q;
   logic                   running;
   logic                   match;
   logic                   start;
   logic                   sample_en;

   tcap_sync #(.W(NCH), .STAGES(2)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (probe_in),
      .q_sync  (smp)
   );

   tcap_ratediv #(.DIVW(DIVW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_div (rate_div),
      .tick     (tick)
   );

   assign running   = (state_q == ACQ_RUN);
   assign match     = (((smp ^ trig_value) & trig_mask) == '0);
   assign start     = tick && !running && match;
   assign sample_en = tick && (pend == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ACQ_ARMED;
      end else if (start) begin
         state_q <= ACQ_RUN;
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_lane
         tcap_lane #(.DW(DW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .running    (running),
            .start      (start),
            .tick       (tick),
            .sample_en  (sample_en),
            .level_in   (smp[c]),
            .glitch_en  (glitch_en),
            .glitch_thr (glitch_thr),
            .grant      (grant[c]),
            .pend       (pend[c]),
            .out_level  (lane_level[c]),
            .out_delta  (lane_delta[c]),
            .out_keep   (lane_keep[c])
         );
      end
   endgenerate

   tcap_fmt #(.NCH(NCH), .DW(DW), .CW(CW)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend       (pend),
      .lane_level (lane_level),
      .lane_delta (lane_delta),
      .lane_keep  (lane_keep),
      .grant      (grant),
      .rec_valid  (rec_valid),
      .rec_ready  (rec_ready),
      .rec_chan   (rec_chan),
      .rec_level  (rec_level),
      .rec_delta  (rec_delta),
      .rec_keep   (rec_keep)
   );
endmodule

// File: rtl/tcap_engine_chk.sv
module tcap_engine_chk #(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 16
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                running,
   input logic                                glitch_en,
   input logic [DW-1:0]                       glitch_thr,
   input logic                                rec_valid,
   input logic                                rec_ready,
   input logic [tcap_pkg::idx_width(NCH)-1:0] rec_chan,
   input logic                                rec_level,
   input logic [DW-1:0]                       rec_delta,
   input logic                                rec_keep
);
   AST_SILENT_BEFORE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !rec_valid); // R1

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !rec_ready |=> rec_valid && $stable(rec_chan) && $stable(rec_level)
                                  && $stable(rec_delta) && $stable(rec_keep)); // R8

   AST_KEEPALIVE_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_keep |-> (rec_delta == '1)); // R5

   AST_GLITCH_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && glitch_en |-> (rec_delta < glitch_thr) && !rec_keep); // R6

   AST_DELTA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_delta != '0)); // R9
endmodule

bind tcap_engine tcap_engine_chk #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tcap_engine_test.sv
module tcap_engine_test;
   localparam int NCH  = 4;
   localparam int DW   = 6;
   localparam int DIVW = 8;
   localparam int SAT  = (1 << DW) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  probe_in = '0;
   logic [NCH-1:0]  trig_mask = '0;
   logic [NCH-1:0]  trig_value = '0;
   logic [DIVW-1:0] rate_div = '0;
   logic            glitch_en = 1'b0;
   logic [DW-1:0]   glitch_thr = '0;
   logic            rec_valid;
   logic            rec_ready = 1'b1;
   logic [1:0]      rec_chan;
   logic            rec_level;
   logic [DW-1:0]   rec_delta;
   logic            rec_keep;

   int tests = 0;
   int fails = 0;
   int n_rec = 0;
   bit done = 0;
   int          r_ch [0:63];
   int          r_lv [0:63];
   int          r_dl [0:63];
   int          r_kp [0:63];

   always #4 clk = ~clk;

   tcap_engine #(.NCH(NCH), .DW(DW), .DIVW(DIVW)) uut (
      .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .trig_mask(trig_mask),
      .trig_value(trig_value), .rate_div(rate_div), .glitch_en(glitch_en),
      .glitch_thr(glitch_thr), .rec_valid(rec_valid), .rec_ready(rec_ready),
      .rec_chan(rec_chan), .rec_level(rec_level), .rec_delta(rec_delta),
      .rec_keep(rec_keep)
   );

   always @(negedge clk) begin
      if (rst_n && rec_valid && rec_ready && n_rec < 64) begin
         r_ch[n_rec] = int'(rec_chan);
         r_lv[n_rec] = int'(rec_level);
         r_dl[n_rec] = int'(rec_delta);
         r_kp[n_rec] = int'(rec_keep);
         n_rec = n_rec + 1;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic exp_rec(input int i, input int ch, input int lv, input int dl,
                          input int kp, input string req);
      if (i >= n_rec) begin
         check(1'b0, {req, " record missing"}, n_rec, i + 1);
      end else begin
         check(r_ch[i] == ch, {req, " channel"}, r_ch[i], ch);
         check(r_lv[i] == lv, {req, " level"}, r_lv[i], lv);
         check(r_dl[i] == dl, {req, " delta"}, r_dl[i], dl);
         check(r_kp[i] == kp, {req, " keep flag"}, r_kp[i], kp);
      end
   endtask

   task automatic restart(input int div, input logic [NCH-1:0] mask,
                          input logic [NCH-1:0] val, input bit gl, input int thr);
      @(posedge clk); #1;
      rst_n = 1'b0;
      probe_in = '0;
      rec_ready = 1'b1;
      rate_div = DIVW'(div);
      trig_mask = mask;
      trig_value = val;
      glitch_en = gl;
      glitch_thr = DW'(thr);
      step(4);
      n_rec = 0;
      rst_n = 1'b1;
      step(3);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1 / R2 / R3: trigger on ch0 high, idle toggles of ch2 beforehand
      restart(0, 4'b0001, 4'b0001, 1'b0, 0);
      check(rec_valid == 1'b0, "R1 reset valid", int'(rec_valid), 0);
      probe_in = 4'b0100; step(5);
      probe_in = 4'b0000; step(5);
      probe_in = 4'b0100; step(5);
      check(n_rec == 0, "R1 R2 no record before trigger", n_rec, 0);
      probe_in = 4'b0101;          // trigger, ch2 reference is 1
      step(10); probe_in = 4'b0111; // ch1 up, 10 ticks
      step(7);  probe_in = 4'b0101; // ch1 down, 7 ticks
      step(6);  probe_in = 4'b0001; // ch2 down, 23 ticks since trigger
      step(10);
      check(n_rec == 3, "R3 record count", n_rec, 3);
      exp_rec(0, 1, 1, 10, 0, "R3 first edge");
      exp_rec(1, 1, 0, 7, 0, "R3 second edge");
      exp_rec(2, 2, 0, 23, 0, "R2 reference level");

      // R4: divider sweep, delta in ticks
      for (int d = 0; d < 4; d++) begin
         for (int k = 3; k < 7; k++) begin
            restart(d, 4'b0001, 4'b0001, 1'b0, 0);
            probe_in = 4'b0001;
            step(k * (d + 1));
            probe_in = 4'b1001;
            step(8 * (d + 1));
            check(n_rec == 1, "R4 one record", n_rec, 1);
            if (n_rec >= 1)
               check(r_dl[0] == k && r_ch[0] == 3, "R4 tick delta", r_dl[0], k);
         end
      end

      // R7 / R8: simultaneous edges and back-pressure
      restart(0, 4'b0001, 4'b0001, 1'b0, 0);
      probe_in = 4'b0001;
      step(8);
      rec_ready = 1'b0;
      probe_in = 4'b1011;          // ch1 and ch3 up together, 8 ticks
      step(4);
      probe_in = 4'b1111;          // ch2 up while stalled
      step(7);
      @(negedge clk);
      check(rec_valid == 1'b1, "R8 held valid", int'(rec_valid), 1);
      check(int'(rec_chan) == 1, "R8 held channel", int'(rec_chan), 1);
      check(int'(rec_delta) == 8, "R8 held delta", int'(rec_delta), 8);
      check(n_rec == 0, "R8 nothing accepted", n_rec, 0);
      @(posedge clk); #1;
      rec_ready = 1'b1;            // raised after edge c+20
      step(10);
      check(n_rec == 3, "R8 no loss", n_rec, 3);
      exp_rec(0, 1, 1, 8, 0, "R7 lower channel first");
      exp_rec(1, 3, 1, 8, 0, "R7 higher channel second");
      exp_rec(2, 2, 1, 19, 0, "R8 paused delta");

      // R6: glitch filter, threshold 5 exclusive
      restart(0, 4'b0001, 4'b0001, 1'b1, 5);
      probe_in = 4'b0001;
      step(10); probe_in = 4'b0011; // 10: dropped
      step(3);  probe_in = 4'b0001; // 3: kept
      step(5);  probe_in = 4'b0011; // 5: dropped (boundary)
      step(4);  probe_in = 4'b0001; // 4: kept
      step(8);
      check(n_rec == 2, "R6 kept count", n_rec, 2);
      exp_rec(0, 1, 0, 3, 0, "R6 short edge");
      exp_rec(1, 1, 0, 4, 0, "R6 short edge");
      step(90);
      check(n_rec == 2, "R5 R6 no keep-alive in glitch mode", n_rec, 2);

      // R2 / R5 / R7: empty mask fires at once, keep-alive after saturation
      restart(0, 4'b0000, 4'b0000, 1'b0, 0);
      step(55);
      check(n_rec == 0, "R5 quiet before saturation", n_rec, 0);
      step(30);
      check(n_rec == 4, "R5 keep-alive count", n_rec, 4);
      for (int c = 0; c < NCH; c++)
         exp_rec(c, c, 0, SAT, 1, "R5 keep-alive");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule